// File: doc/BRIEF.md
# Lifting-Step Sample Address Sequencer

This block owns the single address port of a sample memory that holds one image column. While the block is idle, a host byte stream fills the memory and supplies its own write address. A start command then switches the port to an internal sequencer. The sequencer walks the column in lifting-step triples. For each triple it reads the left, centre and right neighbours one after another on the shared port. It hands the three values to an external arithmetic unit, waits until that unit reports a result, and writes the result back over the centre location.

The memory is synchronous and has one cycle of read latency. Each read address is therefore followed by a wait state, and the data is captured at the end of that wait state. A pass-select bit picks one of two passes. The odd pass starts with the triple at 0 and its centres land on odd addresses. The even pass starts with the triple at 1 and its centres land on even addresses. In both passes the triples advance by two. The block raises a one-cycle completion pulse after the final write-back. The memory itself and the arithmetic live outside the block, so it can sit next to any RAM and any lifting datapath.

Top module: `lift_addr_seq`

## Requirements
- R1: During and after a synchronous active-high reset the block is idle: `busy`, `done`, `calc_start` and `mem_we` are 0, and `mem_addr` follows `ld_addr`.
- R2: While idle, the memory port passes the loader through combinationally: `mem_addr`=`ld_addr`, `mem_we`=`ld_valid`, `mem_wdata`=`ld_data`.
- R3: `go` with `go_shift`=0 starts the odd pass. In the cycle after `go`, `busy` is 1 and `mem_addr` is 0. The pass then processes the triples (2k, 2k+1, 2k+2) for k = 0 .. DEPTH/2-2, in increasing k.
- R4: `go` with `go_shift`=1 starts the even pass. In the cycle after `go`, `mem_addr` is 1. The pass then processes the triples (2k+1, 2k+2, 2k+3) for k = 0 .. DEPTH/2-2.
- R5: For each triple, the memory is read at the left, centre and right addresses in that order. Each read address is held for one cycle and followed by one wait cycle. When `calc_start` is high, `calc_left`, `calc_mid` and `calc_right` equal the stored contents of those three addresses.
- R6: `calc_start` is high for exactly one cycle per triple.
- R7: After `calc_start`, no write-back occurs until `calc_valid` is seen in a cycle after the start cycle. The cycle that follows is the only write cycle of the triple: `mem_we`=1, `mem_addr`= centre, and `mem_wdata` = the `calc_result` sampled with `calc_valid`. A `calc_valid` during the write-back cycle is ignored.
- R8: `done` is high for one cycle, in the cycle right after the last write-back. `busy` is 0 in that cycle.
- R9: `ld_valid` while busy writes nothing, and the port carries only the sequencer's accesses.
- R10: `go` while busy is ignored, and the running pass keeps its order and parity.
- R11: After a pass, each centre location of that pass holds its result, and every other location is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Host stream write strobe |
| ld_addr | input | AW | Host stream write address |
| ld_data | input | DW | Host stream write data |
| go | input | 1 | Start a pass (honoured only when idle) |
| go_shift | input | 1 | 0 = odd pass from address 0, 1 = even pass from address 1 |
| mem_addr | output | AW | Shared memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the address |
| calc_start | output | 1 | Operands ready for the arithmetic unit |
| calc_left | output | DW | Left neighbour value |
| calc_mid | output | DW | Centre value |
| calc_right | output | DW | Right neighbour value |
| calc_valid | input | 1 | Arithmetic result valid |
| calc_result | input | DW | Arithmetic result |
| busy | output | 1 | Pass in progress; port owned by the sequencer |
| done | output | 1 | One-cycle pulse after the final write-back |

## Verification
Two functions can fall in the same cycle. One is a host stream write or a fresh `go`. The other is the sequencer's own read or write-back on the shared port. To provoke this, the bench keeps firing random `ld_valid` strobes, with random addresses and data, and occasional `go` pulses of the opposite parity throughout each pass. Several of these land on write-back cycles. A second collision comes from the arithmetic model: it sometimes holds `calc_valid` high with junk data across the write-back cycle. The bench judges all of this at the port. Every observed write must go to the expected centre with the expected result, and the final memory image must match a reference image built only from the pass rules.

// File: rtl/lift_pkg.sv
package lift_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_L, ST_WT_L,
    ST_ADR_M, ST_WT_M,
    ST_ADR_R, ST_WT_R,
    ST_KICK,  ST_HOLD,
    ST_PUT
  } seq_state_t;

  localparam int unsigned NUM_OPND = 3;

endpackage

// File: rtl/lift_seq_fsm.sv
module lift_seq_fsm
  import lift_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic                go_shift,
  input  logic                calc_valid,
  output logic [AW-1:0]       seq_addr,
  output logic                seq_we,
  output logic [NUM_OPND-1:0] cap_en,
  output logic                calc_start,
  output logic                rslt_take,
  output logic                wb_fire,
  output logic                busy,
  output logic                done
);

  function automatic logic [AW-1:0] start_of(input logic sh);
    return sh ? AW'(1) : '0;
  endfunction

  function automatic logic [AW-1:0] stop_of(input logic sh);
    return sh ? AW'(DEPTH - 3) : AW'(DEPTH - 4);
  endfunction

  function automatic logic [AW-1:0] nbr(input logic [AW-1:0] l, input logic [1:0] k);
    return l + AW'(k);
  endfunction

  seq_state_t      state;
  logic [AW-1:0]   left_q;
  logic            shift_q;
  logic            done_q;
  logic            at_last;

  assign at_last = (left_q == stop_of(shift_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      left_q  <= '0;
      shift_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (go) begin
          shift_q <= go_shift;
          left_q  <= start_of(go_shift);
          state   <= ST_ADR_L;
        end
        ST_ADR_L: state <= ST_WT_L;
        ST_WT_L:  state <= ST_ADR_M;
        ST_ADR_M: state <= ST_WT_M;
        ST_WT_M:  state <= ST_ADR_R;
        ST_ADR_R: state <= ST_WT_R;
        ST_WT_R:  state <= ST_KICK;
        ST_KICK:  state <= ST_HOLD;
        ST_HOLD:  if (calc_valid) state <= ST_PUT;
        ST_PUT: begin
          if (at_last) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            left_q <= left_q + AW'(2);
            state  <= ST_ADR_L;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_ADR_L, ST_WT_L:         seq_addr = nbr(left_q, 2'd0);
      ST_ADR_M, ST_WT_M, ST_PUT: seq_addr = nbr(left_q, 2'd1);
      ST_ADR_R, ST_WT_R:         seq_addr = nbr(left_q, 2'd2);
      default:                   seq_addr = left_q;
    endcase
  end

  assign cap_en     = {state == ST_WT_R, state == ST_WT_M, state == ST_WT_L};
  assign calc_start = (state == ST_KICK);
  assign rslt_take  = (state == ST_HOLD) && calc_valid;
  assign wb_fire    = (state == ST_PUT);
  assign seq_we     = wb_fire;
  assign busy       = (state != ST_IDLE);
  assign done       = done_q;

  p_first_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && go) |=> (busy && seq_addr == start_of($past(go_shift))));

  p_centre_parity_r4: assert property (@(posedge clk) disable iff (rst)
    wb_fire |-> (seq_addr[0] != shift_q));

  p_kick_single_r6: assert property (@(posedge clk) disable iff (rst)
    calc_start |=> !calc_start);

  p_take_then_put_r7: assert property (@(posedge clk) disable iff (rst)
    rslt_take |=> wb_fire);

  p_put_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    wb_fire |-> $past(rslt_take));

  p_done_after_put_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(wb_fire) && !busy));

  p_shift_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(shift_q));

endmodule

// File: rtl/lift_operand_regs.sv
module lift_operand_regs
  import lift_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [DW-1:0]                rd_data,
  input  logic [NUM_OPND-1:0]          cap_en,
  input  logic                         rslt_take,
  input  logic [DW-1:0]                rslt_in,
  output logic [NUM_OPND-1:0][DW-1:0]  opnd,
  output logic [DW-1:0]                rslt_q
);

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    always_ff @(posedge clk) begin
      if (rst)            opnd[g] <= '0;
      else if (cap_en[g]) opnd[g] <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            rslt_q <= '0;
    else if (rslt_take) rslt_q <= rslt_in;
  end

  p_cap_single_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cap_en));

  p_cap_order_r5: assert property (@(posedge clk) disable iff (rst)
    cap_en[1] |-> $past(cap_en[0], 2));

endmodule

// File: rtl/lift_port_mux.sv
module lift_port_mux #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          sel_seq,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] seq_addr,
  input  logic          seq_we,
  input  logic [DW-1:0] seq_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata
);

  always_comb begin
    if (sel_seq) begin
      mem_addr  = seq_addr;
      mem_we    = seq_we;
      mem_wdata = seq_data;
    end else begin
      mem_addr  = ld_addr;
      mem_we    = ld_valid;
      mem_wdata = ld_data;
    end
  end

endmodule

// File: rtl/lift_addr_seq.sv
module lift_addr_seq
  import lift_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          go,
  input  logic          go_shift,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          calc_start,
  output logic [DW-1:0] calc_left,
  output logic [DW-1:0] calc_mid,
  output logic [DW-1:0] calc_right,
  input  logic          calc_valid,
  input  logic [DW-1:0] calc_result,
  output logic          busy,
  output logic          done
);

  logic [AW-1:0]               seq_addr;
  logic                        seq_we;
  logic [NUM_OPND-1:0]         cap_en;
  logic                        rslt_take;
  logic                        wb_fire;
  logic [NUM_OPND-1:0][DW-1:0] opnd;
  logic [DW-1:0]               rslt_q;

  lift_seq_fsm #(.DEPTH(DEPTH), .AW(AW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .go_shift   (go_shift),
    .calc_valid (calc_valid),
    .seq_addr   (seq_addr),
    .seq_we     (seq_we),
    .cap_en     (cap_en),
    .calc_start (calc_start),
    .rslt_take  (rslt_take),
    .wb_fire    (wb_fire),
    .busy       (busy),
    .done       (done)
  );

  lift_operand_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .rd_data   (mem_rdata),
    .cap_en    (cap_en),
    .rslt_take (rslt_take),
    .rslt_in   (calc_result),
    .opnd      (opnd),
    .rslt_q    (rslt_q)
  );

  lift_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .sel_seq   (busy),
    .ld_valid  (ld_valid),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .seq_addr  (seq_addr),
    .seq_we    (seq_we),
    .seq_data  (rslt_q),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
  );

  assign calc_left  = opnd[0];
  assign calc_mid   = opnd[1];
  assign calc_right = opnd[2];

  p_no_loader_write_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_we) |-> wb_fire);

  p_wdata_is_result_r7: assert property (@(posedge clk) disable iff (rst)
    wb_fire |-> (mem_wdata == $past(calc_result)));

  p_operands_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !calc_start && $past(calc_start)) |->
      ($stable(calc_left) && $stable(calc_mid) && $stable(calc_right)));

endmodule

// File: tb/sim_lift_addr_seq.sv
module sim_lift_addr_seq;

  localparam int DEPTH = 256;
  localparam int DW    = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int NTRI  = DEPTH / 2 - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic          ld_valid;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;
  logic          go, go_shift;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          calc_start, calc_valid;
  logic [DW-1:0] calc_left, calc_mid, calc_right, calc_result;
  logic          busy, done;

  always #10 clk = ~clk;

  lift_addr_seq #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .go(go), .go_shift(go_shift), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .calc_start(calc_start),
    .calc_left(calc_left), .calc_mid(calc_mid), .calc_right(calc_right),
    .calc_valid(calc_valid), .calc_result(calc_result), .busy(busy), .done(done)
  );

  logic [DW-1:0] ram     [DEPTH];
  logic [DW-1:0] ref_mem [DEPTH];

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_left;
  logic [DW-1:0] exp_res;
  int wb_seen;
  int last_wb_cyc;
  bit pass_on = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] lift_calc(input logic [DW-1:0] l, m, r);
    logic [DW:0] s;
    s = {1'b0, l} + {1'b0, r};
    return m - s[DW:1];
  endfunction

  // arithmetic unit model: random latency, junk valid during write-back
  initial begin
    calc_valid  = 1'b0;
    calc_result = '0;
    forever begin
      @(negedge clk);
      if (calc_start) begin
        chk(calc_left  == ref_mem[exp_left],     "R5", "left operand",  calc_left,  ref_mem[exp_left]);
        chk(calc_mid   == ref_mem[exp_left + 1], "R5", "mid operand",   calc_mid,   ref_mem[exp_left + 1]);
        chk(calc_right == ref_mem[exp_left + 2], "R5", "right operand", calc_right, ref_mem[exp_left + 2]);
        exp_res = lift_calc(ref_mem[exp_left], ref_mem[exp_left + 1], ref_mem[exp_left + 2]);
        begin
          int d;
          d = 1 + int'($urandom % 4);
          for (int i = 0; i < d; i++) begin
            @(negedge clk);
            if (i == 0) chk(!calc_start, "R6", "start pulse width", calc_start, 0);
            chk(!mem_we, "R7", "write before result", mem_we, 0);
          end
        end
        calc_valid  = 1'b1;
        calc_result = exp_res;
        @(negedge clk);
        calc_valid  = ($urandom % 2) == 0;
        calc_result = ~exp_res;
        @(negedge clk);
        calc_valid  = 1'b0;
      end
    end
  end

  // write-back monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pass_on && mem_we) begin
        chk(mem_addr == AW'(exp_left + 1), "R7 R9 R10", "write-back address", mem_addr, exp_left + 1);
        chk(mem_wdata == exp_res, "R7", "write-back data", mem_wdata, exp_res);
        ref_mem[exp_left + 1] = exp_res;
        exp_left += 2;
        wb_seen++;
        last_wb_cyc = cyc;
      end
    end
  end

  task automatic load_all(input int kind);
    for (int i = 0; i < DEPTH; i++) begin
      int a;
      logic [DW-1:0] v;
      a = (i * 37 + 5) % DEPTH;
      v = (kind == 0) ? DW'($urandom) : (kind == 1) ? '1 : '0;
      @(negedge clk);
      ld_valid = 1'b1;
      ld_addr  = AW'(a);
      ld_data  = v;
      ref_mem[a] = v;
      #1;
      if (i < 8)
        chk(mem_we && mem_addr == AW'(a) && mem_wdata == v, "R2", "loader passthrough",
            {mem_we, mem_addr, mem_wdata}, {1'b1, AW'(a), v});
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run_pass(input bit sh);
    int guard;
    exp_left = sh ? 1 : 0;
    wb_seen  = 0;
    pass_on  = 1'b1;
    @(negedge clk);
    go = 1'b1;
    go_shift = sh;
    @(negedge clk);
    go = 1'b0;
    go_shift = ~sh;
    if (sh) chk(busy && mem_addr == AW'(1) && !mem_we, "R4", "even first address", mem_addr, 1);
    else    chk(busy && mem_addr == '0 && !mem_we,    "R3", "odd first address",  mem_addr, 0);
    fork
      begin
        guard = 0;
        while (!done && guard < 20000) begin
          @(negedge clk);
          guard++;
        end
        chk(done == 1'b1, "R8", "done seen", done, 1);
        chk(wb_seen == NTRI, sh ? "R4" : "R3", "triple count", wb_seen, NTRI);
        chk(cyc == last_wb_cyc + 1, "R8", "done follows last write", cyc, last_wb_cyc + 1);
        chk(!busy, "R8", "idle at done", busy, 0);
        @(negedge clk);
        chk(!done, "R8", "done one cycle", done, 0);
      end
      begin
        while (wb_seen < NTRI - 4) begin
          @(negedge clk);
          go       = ($urandom % 40) == 0;
          ld_valid = ($urandom % 3) == 0;
          ld_addr  = AW'($urandom);
          ld_data  = DW'($urandom);
        end
        @(negedge clk);
        go = 1'b0;
        ld_valid = 1'b0;
      end
    join
    pass_on = 1'b0;
    begin
      int bad;
      bad = -1;
      for (int i = DEPTH - 1; i >= 0; i--) if (ram[i] !== ref_mem[i]) bad = i;
      chk(bad < 0, "R11 R9", "memory image", (bad < 0) ? 0 : ram[bad], (bad < 0) ? 0 : ref_mem[bad]);
    end
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst = 1'b1; ld_valid = 1'b0; ld_addr = AW'(8'h5A); ld_data = '0;
    go = 1'b1; go_shift = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !calc_start && !mem_we, "R1", "reset outputs",
        {busy, done, calc_start, mem_we}, 0);
    chk(mem_addr == ld_addr, "R1", "reset mux", mem_addr, ld_addr);
    go = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R1", "idle after reset", busy, 0);

    load_all(0);
    run_pass(1'b0);
    repeat (5) @(negedge clk);
    chk(!done && !busy, "R8", "quiet after pass", {done, busy}, 0);
    run_pass(1'b1);
    load_all(1);
    run_pass(1'b1);
    load_all(2);
    run_pass(1'b0);
    load_all(0);
    run_pass(1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule